// File: doc/BRIEF.md
# CAN Fault Confinement State Tracker

This block follows the error standing of one CAN node. It holds a receive error counter of eight bits and a transmit error counter one bit wider, so that a transmit count beyond 255 can be seen. The bit-level error detection logic sits elsewhere. That logic sends increment and decrement pulses, and each pulse carries a step size. From the two counts the tracker derives three status flags: warning, error-passive and bus-off. It also raises one-cycle interrupt requests when a counter first climbs into the warning or passive range.

The tracker also keeps a three-bit last-error code. The code is loaded when a frame completes with an error and is kept across later frames. Software may only write zero to it. Only the hardware can clear the status flags. Warning and passive drop as soon as both counts are back at or below their limits. Bus-off stays set until the recovery input or reset clears both counters. All pins are plain control and status levels or pulses, so there is no handshake on any of them.

Top module: `can_fault_tracker`

## Requirements
- R1: After reset both counters, all three flags, both interrupt requests and the last-error code are zero.
- R2: An increment pulse adds the step input to its counter on the next clock edge. A decrement pulse subtracts the step and stops at zero. The receive counter stops at 255 on increment. When increment and decrement arrive together, the increment is applied and the decrement is dropped.
- R3: `warn_o` is high exactly when either counter is above 96. It falls in the same cycle in which both counters are at or below 96.
- R4: `passive_o` is high exactly when either counter is above 127. It falls in the same cycle in which both counters are at or below 127.
- R5: `busoff_o` rises at the edge where the transmit counter goes above 255. It then stays high, and both counters ignore all pulses while it is high.
- R6: A `recover_i` pulse zeroes both counters and clears `busoff_o` at the next edge. It takes priority over any counter pulse in the same cycle.
- R7: While `warn_irq_en_i` is high, `warn_irq_o` is high for one cycle: the first cycle in which a counter shows 96 or more after showing less than 96. While the enable is low, the pulse does not occur.
- R8: While `pass_irq_en_i` is high, `pass_irq_o` is high for one cycle: the first cycle in which a counter shows more than 127 after showing 127 or less. While the enable is low, the pulse does not occur.
- R9: `frame_err_i` loads `err_code_i` into `lec_o` at the next edge. The value is held across any number of idle cycles. `lec_clr_i` writes zero. If both arrive in the same cycle, the capture wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tec_inc_i | input | 1 | Transmit counter increment pulse |
| tec_dec_i | input | 1 | Transmit counter decrement pulse |
| tec_step_i | input | 4 | Transmit counter step size |
| rec_inc_i | input | 1 | Receive counter increment pulse |
| rec_dec_i | input | 1 | Receive counter decrement pulse |
| rec_step_i | input | 4 | Receive counter step size |
| recover_i | input | 1 | Clears both counters and the bus-off state |
| warn_irq_en_i | input | 1 | Enable for the warning interrupt request |
| pass_irq_en_i | input | 1 | Enable for the passive interrupt request |
| frame_err_i | input | 1 | Frame finished with an error; capture the code |
| err_code_i | input | 3 | Error code to capture (0 means no error) |
| lec_clr_i | input | 1 | Software write of zero to the last-error code |
| tec_o | output | 9 | Transmit error count |
| rec_o | output | 8 | Receive error count |
| warn_o | output | 1 | Warning flag |
| passive_o | output | 1 | Error-passive flag |
| busoff_o | output | 1 | Bus-off flag |
| warn_irq_o | output | 1 | Warning interrupt request pulse |
| pass_irq_o | output | 1 | Passive interrupt request pulse |
| lec_o | output | 3 | Held last-error code |

## Verification
The bench drives each counter to exactly 96 and then to 97, and to 127 and then to 128. This catches a design that tests with "at or above" where "above" is required: its flag would rise one step early. It also drives decrements past zero, increments past 255 and simultaneous increment and decrement pulses. A design without a floor or ceiling would wrap to a large or small count, and one with the wrong priority would step the wrong way. The bench pushes the transmit count to exactly 255 and then beyond, and then sends more pulses. A design that sets bus-off one step early, or lets the counters keep moving during bus-off, shows a wrong count. The interrupt requests are checked for a single-cycle width and for silence when disabled. The last-error code is checked for retention across idle cycles and for the capture-over-clear priority.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;

  localparam int unsigned WARN_LIMIT = 96;
  localparam int unsigned PASS_LIMIT = 127;
  localparam int unsigned CMP_W      = 16;

  typedef logic [CMP_W-1:0] cmp_t;

  // true when a count moves from below lim to at-or-above lim
  function automatic logic climbs_to(input cmp_t cur, input cmp_t nxt, input cmp_t lim);
    return (cur < lim) && (nxt >= lim);
  endfunction

endpackage

// File: rtl/can_err_counter.sv
module can_err_counter #(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              hold_i,
  input  logic              inc_i,
  input  logic              dec_i,
  input  logic [STEP_W-1:0] step_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  cnt_nxt_o
);

  localparam int unsigned EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [EXT_W-1:0] step_ext;
  logic [EXT_W-1:0] sum;

  assign step_ext = EXT_W'(step_i);
  assign sum      = {1'b0, cnt_q} + step_ext;

  always_comb begin
    cnt_nxt_o = cnt_q;
    if (clr_i) begin
      cnt_nxt_o = '0;
    end else if (!hold_i) begin
      if (inc_i) begin
        cnt_nxt_o = sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
      end else if (dec_i) begin
        if ({1'b0, cnt_q} < step_ext) cnt_nxt_o = '0;
        else                          cnt_nxt_o = cnt_q - step_ext[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt_o;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/can_fc_status.sv
module can_fc_status
  import can_fc_pkg::*;
#(
  parameter int unsigned REC_W = 8,
  parameter int unsigned TEC_W = REC_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             recover_i,
  input  logic             warn_irq_en_i,
  input  logic             pass_irq_en_i,
  input  logic [TEC_W-1:0] tec_i,
  input  logic [TEC_W-1:0] tec_nxt_i,
  input  logic [REC_W-1:0] rec_i,
  input  logic [REC_W-1:0] rec_nxt_i,
  output logic             warn_o,
  output logic             passive_o,
  output logic             busoff_o,
  output logic             warn_irq_o,
  output logic             pass_irq_o
);

  localparam int unsigned NCNT = 2;

  cmp_t cur [NCNT];
  cmp_t nxt [NCNT];
  logic [NCNT-1:0] over_warn, over_pass, hit_warn, hit_pass;

  assign cur[0] = cmp_t'(tec_i);
  assign nxt[0] = cmp_t'(tec_nxt_i);
  assign cur[1] = cmp_t'(rec_i);
  assign nxt[1] = cmp_t'(rec_nxt_i);

  for (genvar g = 0; g < NCNT; g++) begin : g_cmp
    assign over_warn[g] = cur[g] > cmp_t'(WARN_LIMIT);
    assign over_pass[g] = cur[g] > cmp_t'(PASS_LIMIT);
    assign hit_warn[g]  = climbs_to(cur[g], nxt[g], cmp_t'(WARN_LIMIT));
    assign hit_pass[g]  = climbs_to(cur[g], nxt[g], cmp_t'(PASS_LIMIT + 1));
  end

  assign warn_o    = |over_warn;
  assign passive_o = |over_pass;

  logic busoff_q, warn_irq_q, pass_irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busoff_q   <= 1'b0;
      warn_irq_q <= 1'b0;
      pass_irq_q <= 1'b0;
    end else begin
      busoff_q   <= !recover_i && (busoff_q || tec_nxt_i[TEC_W-1]);
      warn_irq_q <= warn_irq_en_i && (|hit_warn);
      pass_irq_q <= pass_irq_en_i && (|hit_pass);
    end
  end

  assign busoff_o   = busoff_q;
  assign warn_irq_o = warn_irq_q;
  assign pass_irq_o = pass_irq_q;

endmodule

// File: rtl/can_lec_hold.sv
module can_lec_hold #(
  parameter int unsigned LEC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [LEC_W-1:0] code_i,
  input  logic             clr_i,
  output logic [LEC_W-1:0] lec_o
);

  logic [LEC_W-1:0] lec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lec_q <= '0;
    else if (load_i) lec_q <= code_i;
    else if (clr_i)  lec_q <= '0;
  end

  assign lec_o = lec_q;

endmodule

// File: rtl/can_fault_tracker.sv
module can_fault_tracker #(
  parameter int unsigned REC_W  = 8,
  parameter int unsigned STEP_W = 4,
  parameter int unsigned LEC_W  = 3,
  localparam int unsigned TEC_W = REC_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tec_inc_i,
  input  logic              tec_dec_i,
  input  logic [STEP_W-1:0] tec_step_i,
  input  logic              rec_inc_i,
  input  logic              rec_dec_i,
  input  logic [STEP_W-1:0] rec_step_i,
  input  logic              recover_i,
  input  logic              warn_irq_en_i,
  input  logic              pass_irq_en_i,
  input  logic              frame_err_i,
  input  logic [LEC_W-1:0]  err_code_i,
  input  logic              lec_clr_i,
  output logic [TEC_W-1:0]  tec_o,
  output logic [REC_W-1:0]  rec_o,
  output logic              warn_o,
  output logic              passive_o,
  output logic              busoff_o,
  output logic              warn_irq_o,
  output logic              pass_irq_o,
  output logic [LEC_W-1:0]  lec_o
);

  logic [TEC_W-1:0] tec_nxt;
  logic [REC_W-1:0] rec_nxt;
  logic             frozen;

  can_err_counter #(.CNT_W(TEC_W), .STEP_W(STEP_W)) u_tec (
    .clk(clk), .rst_n(rst_n), .clr_i(recover_i), .hold_i(frozen),
    .inc_i(tec_inc_i), .dec_i(tec_dec_i), .step_i(tec_step_i),
    .cnt_o(tec_o), .cnt_nxt_o(tec_nxt)
  );

  can_err_counter #(.CNT_W(REC_W), .STEP_W(STEP_W)) u_rec (
    .clk(clk), .rst_n(rst_n), .clr_i(recover_i), .hold_i(frozen),
    .inc_i(rec_inc_i), .dec_i(rec_dec_i), .step_i(rec_step_i),
    .cnt_o(rec_o), .cnt_nxt_o(rec_nxt)
  );

  can_fc_status #(.REC_W(REC_W), .TEC_W(TEC_W)) u_status (
    .clk(clk), .rst_n(rst_n), .recover_i(recover_i),
    .warn_irq_en_i(warn_irq_en_i), .pass_irq_en_i(pass_irq_en_i),
    .tec_i(tec_o), .tec_nxt_i(tec_nxt), .rec_i(rec_o), .rec_nxt_i(rec_nxt),
    .warn_o(warn_o), .passive_o(passive_o), .busoff_o(frozen),
    .warn_irq_o(warn_irq_o), .pass_irq_o(pass_irq_o)
  );

  assign busoff_o = frozen;

  can_lec_hold #(.LEC_W(LEC_W)) u_lec (
    .clk(clk), .rst_n(rst_n), .load_i(frame_err_i), .code_i(err_code_i),
    .clr_i(lec_clr_i), .lec_o(lec_o)
  );

endmodule

// File: rtl/can_fault_tracker_chk.sv
module can_fault_tracker_chk #(
  parameter int unsigned REC_W  = 8,
  parameter int unsigned STEP_W = 4,
  parameter int unsigned LEC_W  = 3,
  parameter int unsigned TEC_W  = REC_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tec_inc_i,
  input logic              tec_dec_i,
  input logic [STEP_W-1:0] tec_step_i,
  input logic              rec_inc_i,
  input logic              rec_dec_i,
  input logic [STEP_W-1:0] rec_step_i,
  input logic              recover_i,
  input logic              warn_irq_en_i,
  input logic              pass_irq_en_i,
  input logic              frame_err_i,
  input logic [LEC_W-1:0]  err_code_i,
  input logic              lec_clr_i,
  input logic [TEC_W-1:0]  tec_o,
  input logic [REC_W-1:0]  rec_o,
  input logic              warn_o,
  input logic              passive_o,
  input logic              busoff_o,
  input logic              warn_irq_o,
  input logic              pass_irq_o,
  input logic [LEC_W-1:0]  lec_o
);

  // R5
  busoff_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busoff_o && !recover_i |=> busoff_o);

  // R5
  busoff_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busoff_o && !recover_i |=> $stable(tec_o) && $stable(rec_o));

  // R6
  recover_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recover_i |=> (tec_o == '0) && (rec_o == '0) && !busoff_o);

  // R2
  rec_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_o == '0) && rec_dec_i && !rec_inc_i |=> rec_o == '0);

  // R4
  passive_implies_warn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    passive_o |-> warn_o);

  // R7
  warn_irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warn_irq_o |-> (int'(tec_o) >= 96) || (int'(rec_o) >= 96));

  // R7
  warn_irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warn_irq_o |=> !warn_irq_o);

  // R8
  pass_irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_irq_o |=> !pass_irq_o);

  // R9
  lec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_err_i && !lec_clr_i |=> $stable(lec_o));

  // R9
  lec_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err_i |=> lec_o == $past(err_code_i));

endmodule

bind can_fault_tracker can_fault_tracker_chk #(
  .REC_W(REC_W), .STEP_W(STEP_W), .LEC_W(LEC_W), .TEC_W(TEC_W)
) u_chk (.*);

// File: tb/can_fault_tracker_bench.sv
module can_fault_tracker_bench;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0] top;   // bit0 inc, bit1 dec for transmit counter
    logic [1:0] rop;   // same for receive counter
    logic [3:0] ts;
    logic [3:0] rs;
    logic [7:0] n;
    logic [8:0] et;
    logic [7:0] er;
    logic       ew;
    logic       ep;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t TBL [NVEC] = '{
    '{2'd0, 2'd1, 4'd0,  4'd8,  8'd12, 9'd0,   8'd96,  1'b0, 1'b0}, // R3 rec at 96
    '{2'd0, 2'd1, 4'd0,  4'd1,  8'd1,  9'd0,   8'd97,  1'b1, 1'b0}, // R3 rec 97
    '{2'd0, 2'd2, 4'd0,  4'd1,  8'd1,  9'd0,   8'd96,  1'b0, 1'b0}, // R3 falls
    '{2'd1, 2'd0, 4'd15, 4'd0,  8'd9,  9'd135, 8'd96,  1'b1, 1'b1}, // R4
    '{2'd2, 2'd0, 4'd8,  4'd0,  8'd1,  9'd127, 8'd96,  1'b1, 1'b0}, // R4 falls
    '{2'd3, 2'd0, 4'd4,  4'd0,  8'd1,  9'd131, 8'd96,  1'b1, 1'b1}, // R2 inc wins
    '{2'd0, 2'd2, 4'd0,  4'd15, 8'd7,  9'd131, 8'd0,   1'b1, 1'b1}, // R2 floor
    '{2'd0, 2'd1, 4'd0,  4'd15, 8'd20, 9'd131, 8'd255, 1'b1, 1'b1}, // R2 ceiling
    '{2'd0, 2'd2, 4'd0,  4'd15, 8'd17, 9'd131, 8'd0,   1'b1, 1'b1}, // R2
    '{2'd2, 2'd0, 4'd15, 4'd0,  8'd9,  9'd0,   8'd0,   1'b0, 1'b0}  // R3 R4 both low
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tec_inc_i = 0, tec_dec_i = 0, rec_inc_i = 0, rec_dec_i = 0;
  logic [3:0] tec_step_i = 0, rec_step_i = 0;
  logic       recover_i = 0, warn_irq_en_i = 1, pass_irq_en_i = 1;
  logic       frame_err_i = 0, lec_clr_i = 0;
  logic [2:0] err_code_i = 0;
  logic [8:0] tec_o;
  logic [7:0] rec_o;
  logic       warn_o, passive_o, busoff_o, warn_irq_o, pass_irq_o;
  logic [2:0] lec_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_fault_tracker u_can_fault_tracker (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic [1:0] top, input logic [1:0] rop,
                       input logic [3:0] ts, input logic [3:0] rs, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tec_inc_i = top[0]; tec_dec_i = top[1]; tec_step_i = ts;
      rec_inc_i = rop[0]; rec_dec_i = rop[1]; rec_step_i = rs;
    end
    @(negedge clk);
    tec_inc_i = 0; tec_dec_i = 0; rec_inc_i = 0; rec_dec_i = 0;
  endtask

  task automatic do_recover();
    @(negedge clk); recover_i = 1;
    @(negedge clk); recover_i = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 3);
    @(negedge clk);
    // R1 reset state
    chk("R1 tec", tec_o, 0); chk("R1 rec", rec_o, 0);
    chk("R1 flags", {warn_o, passive_o, busoff_o, warn_irq_o, pass_irq_o}, 0);
    chk("R1 lec", lec_o, 0);
    rst_n = 1;

    warn_irq_en_i = 0; pass_irq_en_i = 0;
    for (int v = 0; v < NVEC; v++) begin
      pulse(TBL[v].top, TBL[v].rop, TBL[v].ts, TBL[v].rs, int'(TBL[v].n));
      chk($sformatf("R2 tec vec%0d", v), tec_o, TBL[v].et);
      chk($sformatf("R2 rec vec%0d", v), rec_o, TBL[v].er);
      chk($sformatf("R3 warn vec%0d", v), warn_o, TBL[v].ew);
      chk($sformatf("R4 passive vec%0d", v), passive_o, TBL[v].ep);
    end
    chk("R7 disabled no pulse seen", warn_irq_o, 0);

    // R7 / R8 interrupt pulses
    warn_irq_en_i = 1; pass_irq_en_i = 1;
    pulse(2'd1, 2'd0, 4'd8, 4'd0, 11);       // tec 88
    chk("R7 below 96 no irq", warn_irq_o, 0);
    @(negedge clk); tec_inc_i = 1; tec_step_i = 8;
    @(negedge clk); tec_inc_i = 0;          // tec 96
    chk("R7 irq at 96", warn_irq_o, 1);
    chk("R3 warn at 96", warn_o, 0);
    @(negedge clk);
    chk("R7 single cycle", warn_irq_o, 0);
    pulse(2'd1, 2'd0, 4'd8, 4'd0, 3);        // tec 120
    chk("R8 no irq at 120", pass_irq_o, 0);
    @(negedge clk); tec_inc_i = 1; tec_step_i = 7;
    @(negedge clk); tec_inc_i = 0;          // tec 127
    chk("R8 no irq at 127", pass_irq_o, 0);
    @(negedge clk); tec_inc_i = 1; tec_step_i = 1;
    @(negedge clk); tec_inc_i = 0;          // tec 128
    chk("R8 irq at 128", pass_irq_o, 1);
    @(negedge clk);
    chk("R8 single cycle", pass_irq_o, 0);

    do_recover();
    warn_irq_en_i = 0; pass_irq_en_i = 0;
    @(negedge clk); rec_inc_i = 1; rec_step_i = 15;
    for (int i = 0; i < 9; i++) begin       // rec 0 -> 135 crossing both limits
      @(negedge clk);
      chk("R7 masked", warn_irq_o, 0);
      chk("R8 masked", pass_irq_o, 0);
    end
    rec_inc_i = 0;
    chk("R2 rec 135", rec_o, 135);

    // R5 bus-off and R6 recovery
    do_recover();
    chk("R6 rec cleared", rec_o, 0);
    pulse(2'd1, 2'd0, 4'd15, 4'd0, 17);      // tec 255
    chk("R5 tec 255", tec_o, 255);
    chk("R5 no busoff at 255", busoff_o, 0);
    pulse(2'd1, 2'd0, 4'd15, 4'd0, 1);       // tec 270
    chk("R5 tec 270", tec_o, 270);
    chk("R5 busoff set", busoff_o, 1);
    pulse(2'd2, 2'd1, 4'd15, 4'd9, 3);
    chk("R5 tec frozen", tec_o, 270);
    chk("R5 rec frozen", rec_o, 0);
    chk("R5 busoff sticky", busoff_o, 1);
    chk("R5 passive with busoff", passive_o, 1);
    @(negedge clk); recover_i = 1; tec_inc_i = 1; rec_inc_i = 1;
    @(negedge clk); recover_i = 0; tec_inc_i = 0; rec_inc_i = 0;
    chk("R6 tec cleared", tec_o, 0);
    chk("R6 rec cleared", rec_o, 0);
    chk("R6 busoff cleared", busoff_o, 0);
    chk("R6 warn low", warn_o, 0);

    // R9 last-error code
    @(negedge clk); frame_err_i = 1; err_code_i = 3'd5;
    @(negedge clk); frame_err_i = 0; err_code_i = 3'd2;
    chk("R9 capture", lec_o, 5);
    repeat (6) @(negedge clk);
    chk("R9 held", lec_o, 5);
    @(negedge clk); lec_clr_i = 1;
    @(negedge clk); lec_clr_i = 0;
    chk("R9 cleared", lec_o, 0);
    @(negedge clk); frame_err_i = 1; lec_clr_i = 1; err_code_i = 3'd3;
    @(negedge clk); frame_err_i = 0; lec_clr_i = 0;
    chk("R9 capture beats clear", lec_o, 3);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule